// File: doc/BRIEF.md
# Chained Result Register FIFO

A bank of eight result registers that hold conversion results. Each register is a 16-bit data word plus a valid flag. A configuration vector holds one link bit per register. When a register's link bit is set, that register is tied to the register one index below it. Runs of linked neighbours form FIFO chains.

In a chain, the highest-index register is the only one that accepts new results. The lowest-index register is the only one the CPU reads, and it always holds the oldest result. Registers between the two only pass data along. A register with no link in either direction behaves as a plain result register. Several chains of different depths can exist in the bank at the same time, alongside plain registers.

A new link vector is loaded only by a synchronous clear, which also empties the whole bank.

Top module: `chained_result_fifo`

## Requirements
- R1: After reset or a synchronous clear, every register reads as not valid and `ovf` is low. A clear loads `link_en` as the new layout.
- R2: Results written to a chain's input register are read from its output register in write order. A read with `rd_en` pops the oldest result. A valid output register holds its data while it is not read.
- R3: Data moves one stage toward the output each cycle whenever the lower stage is empty or is being emptied, so no gaps form. In a chain of L registers, a result written to an empty chain in cycle t becomes readable at the output in cycle t+L.
- R4: A write to a chain's input register while it is valid and cannot advance is discarded. `ovf` is then high for exactly the next cycle.
- R5: A write to a standalone register overwrites it, even when it is valid, and never raises `ovf`.
- R6: Writes aimed at a chain's output or intermediate register are ignored.
- R7: A read of a chain's input or intermediate register returns `rd_valid` 0 and pops nothing.
- R8: A write to a full chain's input register is accepted without overflow when the output register is read in the same cycle.
- R9: Changes to `link_en` have no effect until a clear. Link bit 0 has no effect, because register 0 has no lower neighbour.
- R10: Chains and standalone registers in the same bank work independently, for example the layout 0-1, 2-3-4, 5 alone, 6-7 (`link_en` = 8'b1001_1010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; loads the link layout |
| link_en | input | 8 | Per-register link-to-lower-neighbour bits |
| wr_en | input | 1 | Result write strobe |
| wr_idx | input | 3 | Target register of the write |
| wr_data | input | 16 | Result data |
| rd_en | input | 1 | CPU read strobe (pops on a valid output) |
| rd_idx | input | 3 | Register being read |
| rd_data | output | 16 | Data of the addressed register |
| rd_valid | output | 1 | Addressed register is readable and holds data |
| ovf | output | 1 | One-cycle pulse after a discarded write |

## Verification
The hardest state to reach is the cycle where a chain is completely full and a read and a write meet in that same cycle. In that cycle, every stage must shift at once while the input accepts new data. Getting there means first filling a chain with back-to-back writes and no reads. The stimulus does this for the 0-1 chain and for an eight-deep chain. It then confirms that a further write overflows, while a write paired with a read does not. Probes of the output register while the deep chain fills pin down the exact cycle in which the first result arrives.

// File: rtl/chained_result_fifo.sv
module chained_result_fifo #(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [N-1:0]  link_en,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          ovf
);

  logic [N-1:0] cfg, valid, lo, up, wsel, pop, mv, leave, accept, in_mv;
  logic [W-1:0] data [N];
  logic         ovf_d;

  assign lo    = {cfg[N-1:1], 1'b0};
  assign up    = {1'b0, cfg[N-1:1]};
  assign in_mv = {1'b0, mv[N-1:1]};

  always_comb begin
    for (int i = 0; i < N; i++) begin
      wsel[i] = wr_en && (wr_idx == IW'(i)) && !up[i];
      pop[i]  = rd_en && (rd_idx == IW'(i)) && valid[i] && !lo[i];
      if (i == 0) mv[i] = 1'b0;
      else        mv[i] = valid[i] && lo[i] && (!valid[i-1] || leave[i-1]);
      leave[i]  = pop[i] || mv[i];
      accept[i] = wsel[i] && (!lo[i] || !valid[i] || leave[i]);
    end
  end

  assign ovf_d    = |(wsel & lo & valid & ~leave);
  assign rd_data  = data[rd_idx];
  assign rd_valid = valid[rd_idx] && !lo[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      cfg   <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      valid <= '0;
      cfg   <= link_en;
      ovf   <= 1'b0;
    end else begin
      ovf <= ovf_d;
      for (int i = 0; i < N; i++) begin
        if (accept[i])     valid[i] <= 1'b1;
        else if (in_mv[i]) valid[i] <= 1'b1;
        else if (leave[i]) valid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (accept[i])                 data[i] <= wr_data;
      else if (in_mv[i] && i < N-1)  data[i] <= data[(i+1) % N];
    end
  end

  p_ovf_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(wr_en));

  p_no_overflow_standalone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lo[wr_idx] && !up[wr_idx] && !clr) |=> !ovf);

  p_no_overflow_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && up[wr_idx] && !clr) |=> !ovf);

  p_layout_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(cfg));

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_output_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (up[g] && !lo[g] && valid[g] && !clr && !(rd_en && rd_idx == IW'(g)))
      |=> (valid[g] && $stable(data[g])));
    if (g > 0) begin : g_lo
      p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo[g] && valid[g] && !valid[g-1] && !clr) |=> valid[g-1]);
    end
  end

endmodule

// File: tb/test_chained_result_fifo.sv
module test_chained_result_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [7:0]  link_en = 8'b1001_1010;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_idx = '0, rd_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid, ovf;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chained_result_fifo i_chained_result_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .link_en(link_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .ovf(ovf));

  typedef struct packed {
    logic        wr;
    logic [2:0]  widx;
    logic [15:0] wdat;
    logic        rd;
    logic [2:0]  ridx;
    logic        ev;
    logic [15:0] ed;
    logic        eo;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [34] = '{
    '{1'b1,3'd4,16'hA001,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd10}, // R10 chain 2-3-4
    '{1'b1,3'd4,16'hA002,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd3},  // R3
    '{1'b1,3'd4,16'hA003,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd3},
    '{1'b1,3'd4,16'hA004,1'b0,3'd0,1'b0,16'h0000,1'b1,4'd4},  // R4 full
    '{1'b1,3'd3,16'hBAD0,1'b1,3'd2,1'b1,16'hA001,1'b0,4'd6},  // R6 + R2
    '{1'b0,3'd0,16'h0000,1'b1,3'd3,1'b0,16'h0000,1'b0,4'd7},  // R7
    '{1'b1,3'd4,16'hA005,1'b1,3'd2,1'b1,16'hA002,1'b0,4'd2},
    '{1'b0,3'd0,16'h0000,1'b1,3'd2,1'b1,16'hA003,1'b0,4'd2},
    '{1'b0,3'd0,16'h0000,1'b1,3'd2,1'b0,16'h0000,1'b0,4'd3},
    '{1'b0,3'd0,16'h0000,1'b1,3'd2,1'b1,16'hA005,1'b0,4'd3},
    '{1'b0,3'd0,16'h0000,1'b1,3'd2,1'b0,16'h0000,1'b0,4'd2},
    '{1'b1,3'd5,16'hB001,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd5},  // R5 standalone
    '{1'b1,3'd5,16'hB002,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd5},
    '{1'b1,3'd5,16'hB003,1'b1,3'd5,1'b1,16'hB002,1'b0,4'd5},
    '{1'b0,3'd0,16'h0000,1'b1,3'd5,1'b1,16'hB003,1'b0,4'd5},
    '{1'b0,3'd0,16'h0000,1'b1,3'd5,1'b0,16'h0000,1'b0,4'd5},
    '{1'b1,3'd0,16'hC000,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd6},  // R6 output stage
    '{1'b0,3'd0,16'h0000,1'b1,3'd0,1'b0,16'h0000,1'b0,4'd6},
    '{1'b1,3'd1,16'hC001,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd10},
    '{1'b1,3'd1,16'hC002,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd10},
    '{1'b1,3'd1,16'hC003,1'b1,3'd0,1'b1,16'hC001,1'b0,4'd8},  // R8
    '{1'b1,3'd1,16'hC004,1'b0,3'd0,1'b0,16'h0000,1'b1,4'd4},
    '{1'b0,3'd0,16'h0000,1'b1,3'd0,1'b1,16'hC002,1'b0,4'd2},
    '{1'b0,3'd0,16'h0000,1'b1,3'd0,1'b1,16'hC003,1'b0,4'd2},
    '{1'b0,3'd0,16'h0000,1'b1,3'd0,1'b0,16'h0000,1'b0,4'd4},
    '{1'b1,3'd7,16'hD001,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd10}, // chain 6-7
    '{1'b1,3'd6,16'hBAD1,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd6},
    '{1'b0,3'd0,16'h0000,1'b1,3'd6,1'b1,16'hD001,1'b0,4'd3},
    '{1'b1,3'd7,16'hD002,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd10},
    '{1'b1,3'd7,16'hD003,1'b0,3'd0,1'b0,16'h0000,1'b0,4'd10},
    '{1'b0,3'd0,16'h0000,1'b1,3'd7,1'b0,16'h0000,1'b0,4'd7},
    '{1'b0,3'd0,16'h0000,1'b1,3'd6,1'b1,16'hD002,1'b0,4'd2},
    '{1'b0,3'd0,16'h0000,1'b1,3'd6,1'b1,16'hD003,1'b0,4'd2},
    '{1'b0,3'd0,16'h0000,1'b1,3'd6,1'b0,16'h0000,1'b0,4'd2}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] widx, input logic [15:0] wdat,
                      input logic rd, input logic [2:0] ridx, input logic look,
                      input logic ev, input logic [15:0] ed, input logic eo, input string req);
    @(negedge clk);
    wr_en = wr; wr_idx = widx; wr_data = wdat; rd_en = rd; rd_idx = ridx;
    #1;
    if (look) begin
      chk(req, "rd_valid", {31'd0, rd_valid}, {31'd0, ev});
      if (ev) chk(req, "rd_data", {16'd0, rd_data}, {16'd0, ed});
    end
    @(posedge clk); #1;
    chk(req, "ovf", {31'd0, ovf}, {31'd0, eo});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 3'(k), 1, 0, 0, 0, "R1");
    do_clear();

    for (int v = 0; v < 34; v++)
      step(VEC[v].wr, VEC[v].widx, VEC[v].wdat, VEC[v].rd, VEC[v].ridx, VEC[v].rd,
           VEC[v].ev, VEC[v].ed, VEC[v].eo, $sformatf("R%0d row%0d", VEC[v].rq, v));

    // R9: new layout waits for a clear
    step(1, 5, 16'hE001, 0, 0, 0, 0, 0, 0, "R9");
    link_en = 8'h00;
    step(1, 3, 16'hE002, 0, 3, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 3, 1, 0, 0, 0, "R9");
    step(1, 5, 16'hE003, 0, 5, 1, 1, 16'hE001, 0, "R9");
    do_clear();
    step(0, 0, 0, 0, 5, 1, 0, 0, 0, "R1");
    step(1, 3, 16'hE004, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 3, 16'hE005, 0, 3, 1, 1, 16'hE004, 0, "R5");
    step(0, 0, 0, 1, 3, 1, 1, 16'hE005, 0, "R5");

    // R9/R3: all bits set, bit 0 ignored, one eight-deep chain
    link_en = 8'hFF;
    do_clear();
    for (int k = 0; k < 8; k++)
      step(1, 7, 16'hF000 + 16'(k), 0, 0, 1, 0, 0, 0, "R3");
    step(1, 7, 16'hF0EE, 0, 0, 1, 1, 16'hF000, 1, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 7, 16'hF008, 1, 0, 1, 1, 16'hF000, 0, "R8");
    for (int k = 1; k < 9; k++)
      step(0, 0, 0, 1, 0, 1, 1, 16'hF000 + 16'(k), 0, "R2");
    step(0, 0, 0, 1, 0, 1, 0, 0, 0, "R2");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule